// File: doc/BRIEF.md
# Time-Shared Halfband Decimation Cascade

This block reduces a 16-bit sample stream by a factor of 64. It does so with six decimate-by-two halfband filter stages in series. Stages 0 to 4 are 19-tap filters. Stage 5 is a 51-tap filter. All six stages share one pre-add, multiply and accumulate engine.

Each stage keeps its sample history in a circular region of a register file made of 16-word banks. A short stage uses two banks and the long stage uses four. When a stage has taken in two new samples, it has a pair ready. The scheduler then runs the engine on the lowest-numbered stage that has a pair waiting. The result is rounded, clipped to 16 bits and written into the history of the next stage. Results from the last stage leave the block.

Coefficients are loaded through a small write port while the block is held. The same hold input also empties every delay line and clears all scheduling state.

Top module: `hb_cascade`

## Requirements
- R1: After reset, and on the cycle after any clock edge where `hold` is high, `out_valid` is low and `overrun` is low.
- R2: After `hold` is released, exactly one `out_valid` pulse is produced for every 64 accepted input samples. Two pulses are never on adjacent cycles.
- R3: Each stage n computes y = Σ h[k]·x[n−k] once for every second sample it receives, counting from the release of `hold`. h is symmetric. The centre tap h[mid] is coefficient index 0. The taps at mid ± (2j−1) are index j, for j = 1..5 on the 19-tap stages 0–4 and j = 1..13 on the 51-tap stage 5. All other taps are zero.
- R4: Coefficients are signed Q1.15. Each stage result is (acc + 2^14) >> 15 with an arithmetic shift, and is then clipped to the range [−32768, 32767].
- R5: A write on the coefficient port (`cfg_we`, `cfg_stage`, `cfg_tap`, `cfg_val`) takes effect only when `hold` is high and the index is valid for that stage. A write made while `hold` is low leaves the filter response unchanged.
- R6: Holding the block clears every delay line to zero and resets the pair alignment of every stage.
- R7: `overrun` rises when a stage completes a new pair while its previous pair is still waiting. It then stays high until `hold` is asserted.
- R8: The engine always serves the lowest-indexed stage with a pair waiting. With input samples at least 16 cycles apart, `overrun` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Freezes the block, clears delay lines and flags, and enables coefficient writes |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_stage | input | 3 | Stage index for a coefficient write |
| cfg_tap | input | 4 | Coefficient index: 0 = centre, j = pair j |
| cfg_val | input | 16 | Signed Q1.15 coefficient value |
| out_valid | output | 1 | Decimated output strobe |
| out_data | output | 16 | Signed decimated output |
| overrun | output | 1 | Sticky scheduling overrun flag |

## Verification
The hardest condition to reach from the ports is a long-stage computation and a waiting stage-0 pair contending for the engine at the same time, together with a delay-line read that wraps around its bank boundary. Long runs of spaced pseudo-random input reach both conditions naturally. Each output is compared against a direct-form convolution that uses the full zero-stuffed impulse response, rather than the pre-added pair form. A second run uses high-gain coefficients and full-scale DC input to drive the clipping path. A back-to-back input burst forces pairs to pile up faster than the engine can serve them, which exposes the overrun flag and its stickiness.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_FIN} eng_state_e;

  // index of the last nonzero pair coefficient of a halfband filter
  function automatic int hb_pairs(input int taps);
    return (taps + 1) / 4;
  endfunction

  function automatic int hb_mid(input int taps);
    return (taps - 1) / 2;
  endfunction

  function automatic int hb_pow2(input int n);
    int p;
    p = 1;
    for (int i = 0; i < 31; i++) if (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/hb_coef_bank.sv
module hb_coef_bank import hb_pkg::*; #(
  parameter int NSTG       = 6,
  parameter int CW         = 16,
  parameter int SW         = 3,
  parameter int TW         = 4,
  parameter int NTERM      = 14,
  parameter int SHORT_TAPS = 19,
  parameter int LONG_TAPS  = 51,
  parameter int LONG_IDX   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold,
  input  logic                        cfg_we,
  input  logic [SW-1:0]               cfg_stage,
  input  logic [TW-1:0]               cfg_tap,
  input  logic [CW-1:0]               cfg_val,
  input  logic [SW-1:0]               rd_stage,
  input  logic [TW-1:0]               rd_term,
  output logic [CW-1:0]               rd_coef,
  output logic [NSTG*NTERM*CW-1:0]    coef_flat
);
  logic [CW-1:0] cq [NSTG][NTERM];

  function automatic int last_term(input int s);
    return hb_pairs((s == LONG_IDX) ? LONG_TAPS : SHORT_TAPS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTG; s++)
        for (int t = 0; t < NTERM; t++) cq[s][t] <= '0;
    end else if (hold && cfg_we) begin
      for (int s = 0; s < NSTG; s++)
        for (int t = 0; t < NTERM; t++)
          if (cfg_stage == SW'(s) && cfg_tap == TW'(t) && t <= last_term(s))
            cq[s][t] <= cfg_val;
    end
  end

  always_comb begin
    rd_coef = '0;
    for (int s = 0; s < NSTG; s++)
      for (int t = 0; t < NTERM; t++)
        if (rd_stage == SW'(s) && rd_term == TW'(t)) rd_coef = cq[s][t];
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_fs
    for (genvar t = 0; t < NTERM; t++) begin : g_ft
      assign coef_flat[(s*NTERM+t)*CW +: CW] = cq[s][t];
    end
  end
endmodule

// File: rtl/hb_sched.sv
module hb_sched #(
  parameter int NSTG = 6,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [NSTG-1:0] pair_done,
  input  logic            take,
  output logic            any,
  output logic [SW-1:0]   sel,
  output logic [NSTG-1:0] pend,
  output logic            overrun
);
  logic [NSTG-1:0] clr;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int s = NSTG - 1; s >= 0; s--) if (pend[s]) sel = SW'(s);
    any = |pend;
    clr = take ? (NSTG'(1) << sel) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      overrun <= 1'b0;
    end else if (hold) begin
      pend    <= '0;
      overrun <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | pair_done;
      if (|(pair_done & pend & ~clr)) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/hb_mac.sv
module hb_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACCW  = 39,
  parameter int CFRAC = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] coef,
  output logic [DW-1:0] y
);
  localparam int PW = DW + 1;
  localparam int MW = PW + CW;

  logic signed [ACCW-1:0] acc;
  logic signed [MW-1:0]   prod;

  // first term is the centre tap alone; later terms pre-add a symmetric pair
  function automatic logic signed [PW-1:0] pre_sum(input logic [DW-1:0] x0,
                                                   input logic [DW-1:0] x1,
                                                   input logic centre);
    logic signed [PW-1:0] e0, e1;
    e0 = {x0[DW-1], x0};
    e1 = {x1[DW-1], x1};
    return centre ? e0 : e0 + e1;
  endfunction

  function automatic logic [DW-1:0] round_sat(input logic signed [ACCW-1:0] v);
    logic signed [ACCW-1:0] half, r, mx, mn;
    half = ACCW'(1) << (CFRAC - 1);
    mx   = (ACCW'(1) << (DW - 1)) - ACCW'(1);
    mn   = -mx - ACCW'(1);
    r    = (v + half) >>> CFRAC;
    if (r > mx) r = mx;
    else if (r < mn) r = mn;
    return r[DW-1:0];
  endfunction

  assign prod = pre_sum(a, b, first) * $signed(coef);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (en) acc <= (first ? '0 : acc) + {{(ACCW-MW){prod[MW-1]}}, prod};
  end

  assign y = round_sat(acc);
endmodule

// File: rtl/hb_cascade.sv
module hb_cascade import hb_pkg::*; #(
  parameter int NSTG       = 6,
  parameter int DW         = 16,
  parameter int CW         = 16,
  parameter int SHORT_TAPS = 19,
  parameter int LONG_TAPS  = 51,
  parameter int LONG_IDX   = NSTG - 1,
  parameter int BANK_WORDS = 16,
  parameter int GUARD      = 6,
  parameter int CFRAC      = 15,
  parameter int SW         = $clog2(NSTG),
  parameter int TW         = $clog2(hb_pairs(LONG_TAPS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_stage,
  input  logic [TW-1:0] cfg_tap,
  input  logic [CW-1:0] cfg_val,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          overrun
);
  localparam int SHORT_WORDS = BANK_WORDS * hb_pow2((SHORT_TAPS + BANK_WORDS - 1) / BANK_WORDS);
  localparam int LONG_WORDS  = BANK_WORDS * hb_pow2((LONG_TAPS + BANK_WORDS - 1) / BANK_WORDS);
  localparam int TOT_WORDS   = (NSTG - 1) * SHORT_WORDS + LONG_WORDS;
  localparam int AW          = $clog2(TOT_WORDS);
  localparam int PW          = $clog2(LONG_WORDS);
  localparam int NTERM       = hb_pairs(LONG_TAPS) + 1;
  localparam int ACCW        = DW + 1 + CW + GUARD;
  localparam int CFW         = NSTG * NTERM * CW;

  function automatic int taps_of(input int s);
    return (s == LONG_IDX) ? LONG_TAPS : SHORT_TAPS;
  endfunction
  function automatic int depth_of(input int s);
    return (s == LONG_IDX) ? LONG_WORDS : SHORT_WORDS;
  endfunction
  function automatic int base_of(input int s);
    int b;
    b = 0;
    for (int i = 0; i < NSTG; i++) if (i < s) b += depth_of(i);
    return b;
  endfunction

  // delay-line register file and per-stage write state
  logic [DW-1:0]   mem [TOT_WORDS];
  logic [NSTG-1:0] wr_en, pair_done, phase;
  logic [DW-1:0]   wr_dat   [NSTG];
  logic [PW-1:0]   wr_ptr   [NSTG];
  logic [PW-1:0]   pair_ptr [NSTG];

  // engine
  eng_state_e    st;
  logic [SW-1:0] sel_q;
  logic [TW-1:0] term;
  logic [PW-1:0] pp_q, pp_pick, off_a, off_b, msk;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW-1:0] mac_y;
  logic [CW-1:0] coef;
  logic          eng_fin, fin_last, term_zero;
  int            mid_sel, last_sel;

  // scheduler
  logic            sch_any, sch_take;
  logic [SW-1:0]   sch_sel;
  logic [NSTG-1:0] pend_q;
  logic [CFW-1:0]  coef_flat;

  assign eng_fin   = (st == ENG_FIN) && !hold;
  assign fin_last  = eng_fin && (sel_q == SW'(NSTG - 1));
  assign sch_take  = (st == ENG_IDLE) && sch_any && !hold;
  assign term_zero = (term == '0);

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_in
      assign wr_en[s]  = in_valid && !hold;
      assign wr_dat[s] = in_data;
    end else begin : g_chain
      assign wr_en[s]  = eng_fin && (sel_q == SW'(s - 1));
      assign wr_dat[s] = mac_y;
    end
    assign pair_done[s] = wr_en[s] && phase[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_ptr[s]   <= '0;
        pair_ptr[s] <= '0;
        phase[s]    <= 1'b0;
      end else if (hold) begin
        wr_ptr[s]   <= '0;
        pair_ptr[s] <= '0;
        phase[s]    <= 1'b0;
      end else if (wr_en[s]) begin
        wr_ptr[s] <= (wr_ptr[s] + PW'(1)) & PW'(depth_of(s) - 1);
        phase[s]  <= ~phase[s];
        if (phase[s]) pair_ptr[s] <= wr_ptr[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT_WORDS; i++) mem[i] <= '0;
    end else if (hold) begin
      for (int i = 0; i < TOT_WORDS; i++) mem[i] <= '0;
    end else begin
      for (int s = 0; s < NSTG; s++)
        if (wr_en[s]) mem[AW'(base_of(s)) + AW'(wr_ptr[s])] <= wr_dat[s];
    end
  end

  always_comb begin
    pp_pick = '0;
    for (int s = 0; s < NSTG; s++) if (sch_sel == SW'(s)) pp_pick = pair_ptr[s];
  end

  // operand addresses: centre tap, then pairs at mid -/+ (2j-1), modulo the stage depth
  always_comb begin
    mid_sel  = hb_mid(taps_of(int'(sel_q)));
    last_sel = hb_pairs(taps_of(int'(sel_q)));
    msk      = PW'(depth_of(int'(sel_q)) - 1);
    if (term_zero) begin
      off_a = pp_q - PW'(mid_sel);
      off_b = off_a;
    end else begin
      off_a = pp_q - PW'(mid_sel - (2 * int'(term) - 1));
      off_b = pp_q - PW'(mid_sel + (2 * int'(term) - 1));
    end
    addr_a = AW'(base_of(int'(sel_q))) + AW'(off_a & msk);
    addr_b = AW'(base_of(int'(sel_q))) + AW'(off_b & msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      sel_q <= '0;
      term  <= '0;
      pp_q  <= '0;
    end else if (hold) begin
      st <= ENG_IDLE;
    end else begin
      case (st)
        ENG_IDLE: if (sch_any) begin
          st    <= ENG_RUN;
          sel_q <= sch_sel;
          pp_q  <= pp_pick;
          term  <= '0;
        end
        ENG_RUN: if (term == TW'(last_sel)) st <= ENG_FIN;
                 else term <= term + TW'(1);
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin_last;
      if (fin_last) out_data <= mac_y;
    end
  end

  hb_sched #(.NSTG(NSTG), .SW(SW)) u_sched (
    .clk(clk), .rst_n(rst_n), .hold(hold), .pair_done(pair_done), .take(sch_take),
    .any(sch_any), .sel(sch_sel), .pend(pend_q), .overrun(overrun));

  hb_coef_bank #(.NSTG(NSTG), .CW(CW), .SW(SW), .TW(TW), .NTERM(NTERM),
                 .SHORT_TAPS(SHORT_TAPS), .LONG_TAPS(LONG_TAPS), .LONG_IDX(LONG_IDX)) u_coef (
    .clk(clk), .rst_n(rst_n), .hold(hold), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
    .cfg_tap(cfg_tap), .cfg_val(cfg_val), .rd_stage(sel_q), .rd_term(term),
    .rd_coef(coef), .coef_flat(coef_flat));

  hb_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .CFRAC(CFRAC)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(st == ENG_RUN), .first(term_zero),
    .a(mem[addr_a]), .b(mem[addr_b]), .coef(coef), .y(mac_y));
endmodule

// File: rtl/hb_cascade_chk.sv
module hb_cascade_chk #(
  parameter int NSTG = 6,
  parameter int SW   = 3,
  parameter int CFW  = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold,
  input logic            out_valid,
  input logic            overrun,
  input logic            take,
  input logic [SW-1:0]   sel,
  input logic [NSTG-1:0] pend,
  input logic [CFW-1:0]  coef_flat
);
  a_r1_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!out_valid && !overrun));

  a_r2_no_adjacent_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r5_coef_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> $stable(coef_flat));

  a_r6_hold_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pend == '0));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !hold) |=> overrun);

  a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend[sel] && ((pend & ((NSTG'(1) << sel) - NSTG'(1))) == '0)));
endmodule

bind hb_cascade hb_cascade_chk #(.NSTG(NSTG), .SW(SW), .CFW(CFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .out_valid(out_valid), .overrun(overrun),
  .take(sch_take), .sel(sch_sel), .pend(pend_q), .coef_flat(coef_flat));

// File: tb/hb_cascade_test.sv
module hb_cascade_test;
  localparam int NSTG = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_stage = '0;
  logic [3:0]  cfg_tap = '0;
  logic [15:0] cfg_val = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        overrun;

  hb_cascade uut (.clk(clk), .rst_n(rst_n), .hold(hold), .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_tap(cfg_tap), .cfg_val(cfg_val),
    .out_valid(out_valid), .out_data(out_data), .overrun(overrun));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_out = 0, last_out = 0;
  bit ignore_out = 1'b0;
  string cur_req = "R3";
  int cset [NSTG][14];
  int hist [NSTG][$];
  int cnt  [NSTG];
  int exp_q [$];
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int taps_of(input int s);
    return (s == NSTG - 1) ? 51 : 19;
  endfunction

  // full zero-stuffed impulse response, independent of the pair form
  function automatic int coef_h(input int s, input int k);
    int d;
    d = k - (taps_of(s) - 1) / 2;
    if (d == 0) return cset[s][0];
    if (d < 0) d = -d;
    if (d % 2 == 1) return cset[s][(d + 1) / 2];
    return 0;
  endfunction

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NSTG; s++) begin
      hist[s] = {};
      for (int k = 0; k < taps_of(s); k++) hist[s].push_front(0);
      cnt[s] = 0;
    end
    exp_q = {};
    n_out = 0;
  endtask

  task automatic model_push(input int x);
    int v;
    v = x;
    for (int s = 0; s < NSTG; s++) begin
      longint acc;
      hist[s].push_front(v);
      if (hist[s].size() > taps_of(s)) void'(hist[s].pop_back());
      cnt[s]++;
      if (cnt[s] % 2 != 0) return;
      acc = 0;
      for (int k = 0; k < taps_of(s); k++) acc += longint'(coef_h(s, k)) * hist[s][k];
      v = sat16((acc + 16384) >>> 15);
      if (s == NSTG - 1) exp_q.push_back(v);
    end
  endtask

  task automatic prog(input int s, input int t, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stage = 3'(s); cfg_tap = 4'(t); cfg_val = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_set(input bit high_gain);
    for (int s = 0; s < NSTG; s++)
      for (int t = 0; t <= (taps_of(s) + 1) / 4; t++) begin
        int v;
        if (t == 0) v = high_gain ? 16384 : 16384 - 500 * s;
        else if (high_gain) v = 6000;
        else v = ((t % 2) ? 1 : -1) * ((12000 >> (t - 1)) + 13 * s);
        cset[s][t] = v;
        prog(s, t, v);
      end
  endtask

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(x);
    model_push(x);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 40001) - 20000;
  endfunction

  task automatic release_hold();
    @(negedge clk); hold = 1'b0;
    model_clear();
  endtask

  task automatic enter_hold();
    @(negedge clk); hold = 1'b1;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !ignore_out) begin
      n_out++;
      last_out = $signed(out_data);
      if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected output", $signed(out_data), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check($signed(out_data) == e, cur_req, "output sample", $signed(out_data), e);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

    // mixed-sign coefficients, pseudo-random input
    load_set(1'b0);
    release_hold();
    cur_req = "R3";
    for (int i = 0; i < 768; i++) begin
      if (i == 300) begin
        prog(0, 0, 0);   // R5: written while running, must be ignored
        cur_req = "R5";
      end
      send(next_rand());
    end
    repeat (300) @(negedge clk);
    check(n_out == 12, "R2", "outputs for 768 inputs", n_out, 12);
    check(exp_q.size() == 0, "R3", "pending expected items", exp_q.size(), 0);
    check(overrun == 1'b0, "R8", "overrun with spaced input", overrun, 0);

    enter_hold();
    check(out_valid == 1'b0, "R1", "out_valid in hold", out_valid, 0);

    // high-gain set, full-scale DC: clipping
    load_set(1'b1);
    release_hold();
    cur_req = "R4";
    for (int i = 0; i < 512; i++) send(20000);
    repeat (300) @(negedge clk);
    check(n_out == 8, "R2", "outputs for 512 inputs", n_out, 8);
    check(last_out == 32767, "R4", "clipped final output", last_out, 32767);

    // history must be empty again after hold
    enter_hold();
    release_hold();
    cur_req = "R6";
    for (int i = 0; i < 128; i++) send((i % 3 == 0) ? 150 : -90);
    repeat (300) @(negedge clk);
    check(n_out == 2, "R6", "outputs after hold", n_out, 2);
    check(exp_q.size() == 0, "R6", "pending expected items", exp_q.size(), 0);

    // back-to-back burst forces overrun
    enter_hold();
    release_hold();
    ignore_out = 1'b1;
    check(overrun == 1'b0, "R7", "overrun before burst", overrun, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'(i * 100);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(overrun == 1'b1, "R7", "overrun after burst", overrun, 1);
    repeat (50) @(negedge clk);
    check(overrun == 1'b1, "R7", "overrun sticky", overrun, 1);
    enter_hold();
    check(overrun == 1'b0, "R7", "overrun cleared by hold", overrun, 0);
    finish_run();
  end
endmodule